// File: doc/BRIEF.md
# Linked descriptor chain DMA sequencer

This block is a single-channel copy engine that works through a list of transfer descriptors kept in ordinary memory. Each descriptor is four words on a 32-byte boundary. It gives a byte count, a source address, a destination address and a link word. The engine loads a descriptor and copies the data word by word from source to destination. It then follows the link word to the next descriptor, until it meets a descriptor whose link word carries the last-in-list flag. The descriptors and the data share one word-wide memory port. The port allows one access at a time.

Software drives the block through four registers on a small write/read port. The register addresses are: 0 = control, 1 = status, 2 = current descriptor address, 3 = remaining byte count. To start a chain, software writes the address of the first descriptor and then raises the start bit. It can stop a chain with the abort bit. Four sticky events are recorded in status and can each raise the interrupt line:

- chain end;
- segment done;
- programming error;
- transfer error.

A copy longer than one descriptor's count field is split by software into several linked descriptors.

Top module: `chain_dma_seq`

## Requirements
- R1: After reset the control, status, descriptor-address and byte-count registers all read zero, `irq` is low and no memory request is made.
- R2: A control write (address 0) that sets the start bit (bit 0) while that bit is clear starts the channel if it is idle. Status bit 2 (busy) reads one from the next cycle. The four descriptor words are fetched from the descriptor address at byte offsets 0, 4, 8 and 12.
- R3: Descriptor word 0 holds the byte count in bits 11:0. Its two low bits and all bits above 11 are ignored. Word 1 is the source and word 2 the destination, with their two low bits ignored. The engine copies count/4 words in ascending address order.
- R4: In the link word (descriptor word 3), bits 31:5 are the next descriptor address and bits 4:0 are flags. When bit 0 is clear, the descriptor address register (address 2, low five bits always zero) takes the next address and that descriptor is fetched.
- R5: After the last word of a descriptor whose link bit 0 is set, the channel stops. Busy and halted (status bit 3) read zero and the chain-end event (status bit 0) is set.
- R6: The segment-done event (status bit 1) is set when a descriptor with link bit 1 set finishes. It is not set by a descriptor with that bit clear.
- R7: A descriptor whose count gives zero whole words sets the programming-error event (status bit 4). It moves no data and leaves the channel halted and not busy. The byte-count register then reads zero.
- R8: Setting control bit 1 (abort) while busy stops the channel when the current memory access completes. No further access is made, and the status reads halted and not busy. Clearing start and abort and then setting start again restarts the channel from the descriptor address register.
- R9: An error response on any memory access sets the transfer-error event (status bit 5) and leaves the channel halted and not busy.
- R10: Writing a one to an event bit of status clears it, and writing a zero leaves it unchanged. Writes cannot change busy or halted.
- R11: `irq` is high while transfer error or programming error is set with control bit 2, or segment done is set with control bit 3, or chain end is set with control bit 4.
- R12: Once raised, `mem_req` stays high with address, direction and write data unchanged until `mem_ack` is seen, and the engine requests nothing while it is not busy.
- R13: The byte-count register (address 3) reads the bytes still to move in the current descriptor and falls by 4 for each word written. Writes to the descriptor address register while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 control, 1 status, 2 descriptor address, 3 byte count) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt, level |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | AW (32) | Memory byte address, word aligned |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, valid with `mem_ack` |
| mem_ack | input | 1 | Access complete |
| mem_err | input | 1 | Error response, valid with `mem_ack` |

## Verification
The bench targets the count field's edges:
- A count with stray high and low bits must copy exactly one word. A design that used the whole word would overrun the sentinel past the destination.
- A count below one word must end in a programming error with no write. A design that underflowed the count would copy until it wrapped.

Abort arrives in the middle of a long copy. A design that ignored it, or dropped the request mid-handshake, would write the last destination word or trip the handshake monitor.

A memory error on the third source read must leave that destination word untouched and halt the channel. A sloppy design would write stale data or carry on with the chain.

The bench also checks that the link flags are masked out of the next pointer. A design that kept them would fetch the second descriptor from a misaligned address.

// File: rtl/chain_dma_pkg.sv
// Shared constants and types for the descriptor chain DMA sequencer.
// Assumes a 32-bit data word and descriptors aligned to 32 bytes.
package chain_dma_pkg;
    localparam int WORD_W     = 32;
    localparam int ALIGN_BITS = 5;

    // Register addresses
    localparam logic [1:0] RA_MODE  = 2'd0;
    localparam logic [1:0] RA_STAT  = 2'd1;
    localparam logic [1:0] RA_DESC  = 2'd2;
    localparam logic [1:0] RA_COUNT = 2'd3;

    // Control register bits
    localparam int MODE_W    = 5;
    localparam int MB_START  = 0;
    localparam int MB_ABORT  = 1;
    localparam int MB_ERR_EN = 2;
    localparam int MB_SEG_EN = 3;
    localparam int MB_END_EN = 4;

    // Status register bits
    localparam int SB_END  = 0;
    localparam int SB_SEG  = 1;
    localparam int SB_BUSY = 2;
    localparam int SB_HALT = 3;
    localparam int SB_PROG = 4;
    localparam int SB_XERR = 5;

    // Link word flag bits
    localparam int LB_LAST = 0;
    localparam int LB_SEG  = 1;

    typedef enum logic [2:0] {
        ST_IDLE, ST_FETCH, ST_CHECK, ST_READ, ST_WRITE, ST_LINK
    } eng_state_t;

    // One-cycle event pulses from the engine
    typedef struct packed {
        logic xfer_err;
        logic prog_err;
        logic seg_done;
        logic chain_end;
    } evt_t;
endpackage

// File: rtl/chain_dma_engine.sv
// Descriptor walker and copy datapath.
// Fetches four-word descriptors, copies count/4 words and follows the link word.
// Assumes one memory access in flight, held until mem_ack. AW and CNT_W must not exceed 32.
module chain_dma_engine
    import chain_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              abort,
    input  logic              desc_we,
    input  logic [AW-1:0]     desc_wdata,
    output logic [AW-1:0]     desc_addr,
    output logic [CNT_W-1:0]  byte_cnt,
    output logic              busy,
    output logic              halted,
    output evt_t              evt,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err
);
    localparam logic [AW-1:0]    PTR_MASK  = ~(AW'(2**ALIGN_BITS - 1));
    localparam logic [AW-1:0]    WORD_MASK = ~(AW'(3));
    localparam logic [AW-1:0]    ADDR_STEP = AW'(4);
    localparam logic [CNT_W-1:0] CNT_MASK  = ~(CNT_W'(3));
    localparam logic [CNT_W-1:0] CNT_STEP  = CNT_W'(4);

    eng_state_t        state;
    logic [1:0]        widx;
    logic [AW-1:0]     desc_q, src_q, dst_q, link_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              last_q, segf_q, busy_q, halt_q;
    logic [WORD_W-1:0] buf_q;
    logic              done, stop_now;

    // An access completes in the cycle it is acknowledged
    assign done     = mem_req && mem_ack;
    // Error or abort ends the run at the completion of a data or descriptor access
    assign stop_now = done && (mem_err || abort);

    // Memory request decode from the current state
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = '0;
        mem_wdata = buf_q;
        case (state)
            ST_FETCH: begin
                mem_req  = 1'b1;
                mem_addr = desc_q + AW'({widx, 2'b00});
            end
            ST_READ: begin
                mem_req  = 1'b1;
                mem_addr = src_q;
            end
            ST_WRITE: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = dst_q;
            end
            default: ;
        endcase
    end

    // Sequencer state, descriptor fields and event pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            widx   <= '0;
            desc_q <= '0;
            src_q  <= '0;
            dst_q  <= '0;
            link_q <= '0;
            cnt_q  <= '0;
            last_q <= 1'b0;
            segf_q <= 1'b0;
            busy_q <= 1'b0;
            halt_q <= 1'b0;
            buf_q  <= '0;
            evt    <= '0;
        end else begin
            evt <= '0;
            if (stop_now) begin
                evt.xfer_err <= mem_err;
                busy_q       <= 1'b0;
                halt_q       <= 1'b1;
                state        <= ST_IDLE;
            end else begin
                case (state)
                    ST_IDLE: begin
                        if (desc_we) desc_q <= desc_wdata & PTR_MASK;
                        if (go) begin
                            widx   <= '0;
                            busy_q <= 1'b1;
                            halt_q <= 1'b0;
                            state  <= ST_FETCH;
                        end
                    end
                    ST_FETCH: begin
                        if (done) begin
                            case (widx)
                                2'd0: cnt_q <= mem_rdata[CNT_W-1:0] & CNT_MASK;
                                2'd1: src_q <= mem_rdata[AW-1:0] & WORD_MASK;
                                2'd2: dst_q <= mem_rdata[AW-1:0] & WORD_MASK;
                                default: begin
                                    link_q <= mem_rdata[AW-1:0] & PTR_MASK;
                                    last_q <= mem_rdata[LB_LAST];
                                    segf_q <= mem_rdata[LB_SEG];
                                end
                            endcase
                            widx <= widx + 2'd1;
                            if (widx == 2'd3) state <= ST_CHECK;
                        end
                    end
                    ST_CHECK: begin
                        if (abort) begin
                            busy_q <= 1'b0;
                            halt_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else if (cnt_q == '0) begin
                            evt.prog_err <= 1'b1;
                            busy_q       <= 1'b0;
                            halt_q       <= 1'b1;
                            state        <= ST_IDLE;
                        end else begin
                            state <= ST_READ;
                        end
                    end
                    ST_READ: begin
                        if (done) begin
                            buf_q <= mem_rdata;
                            state <= ST_WRITE;
                        end
                    end
                    ST_WRITE: begin
                        if (done) begin
                            cnt_q <= cnt_q - CNT_STEP;
                            src_q <= src_q + ADDR_STEP;
                            dst_q <= dst_q + ADDR_STEP;
                            state <= (cnt_q == CNT_STEP) ? ST_LINK : ST_READ;
                        end
                    end
                    ST_LINK: begin
                        evt.seg_done <= segf_q;
                        if (last_q) begin
                            evt.chain_end <= 1'b1;
                            busy_q        <= 1'b0;
                            state         <= ST_IDLE;
                        end else if (abort) begin
                            busy_q <= 1'b0;
                            halt_q <= 1'b1;
                            state  <= ST_IDLE;
                        end else begin
                            desc_q <= link_q;
                            widx   <= '0;
                            state  <= ST_FETCH;
                        end
                    end
                    default: state <= ST_IDLE;
                endcase
            end
        end
    end

    assign desc_addr = desc_q;
    assign byte_cnt  = cnt_q;
    assign busy      = busy_q;
    assign halted    = halt_q;
endmodule

// File: rtl/chain_dma_regs.sv
// Software register block: control bits, sticky status events, read mux and interrupt.
// Assumes single-cycle register writes. Reads are combinational on reg_addr.
module chain_dma_regs
    import chain_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq,
    output logic              go,
    output logic              abort,
    output logic              desc_we,
    output logic [AW-1:0]     desc_wdata,
    input  logic [AW-1:0]     desc_addr,
    input  logic [CNT_W-1:0]  byte_cnt,
    input  logic              eng_busy,
    input  logic              eng_halted,
    input  evt_t              evt
);
    logic [MODE_W-1:0] mode_q;
    logic [3:0]        flags_q;   // {xfer_err, prog_err, seg_done, chain_end}
    logic [3:0]        clr;
    logic              wr_mode, wr_stat;

    assign wr_mode    = reg_we && (reg_addr == RA_MODE);
    assign wr_stat    = reg_we && (reg_addr == RA_STAT);
    assign desc_we    = reg_we && (reg_addr == RA_DESC);
    assign desc_wdata = reg_wdata[AW-1:0];
    assign go         = wr_mode && reg_wdata[MB_START] && !mode_q[MB_START];
    assign abort      = mode_q[MB_ABORT];
    assign clr        = wr_stat ? {reg_wdata[SB_XERR], reg_wdata[SB_PROG],
                                   reg_wdata[SB_SEG], reg_wdata[SB_END]} : 4'b0;

    // Control register
    always_ff @(posedge clk) begin
        if (!rst_n) mode_q <= '0;
        else if (wr_mode) mode_q <= reg_wdata[MODE_W-1:0];
    end

    // Sticky events: a new event wins over a clear in the same cycle
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else flags_q <= (flags_q & ~clr) | evt;
    end

    // Register read mux
    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            RA_MODE: reg_rdata[MODE_W-1:0] = mode_q;
            RA_STAT: begin
                reg_rdata[SB_END]  = flags_q[0];
                reg_rdata[SB_SEG]  = flags_q[1];
                reg_rdata[SB_BUSY] = eng_busy;
                reg_rdata[SB_HALT] = eng_halted;
                reg_rdata[SB_PROG] = flags_q[2];
                reg_rdata[SB_XERR] = flags_q[3];
            end
            RA_DESC: reg_rdata[AW-1:0]    = desc_addr;
            default: reg_rdata[CNT_W-1:0] = byte_cnt;
        endcase
    end

    // Level interrupt from enabled events
    assign irq = (mode_q[MB_ERR_EN] && (flags_q[3] || flags_q[2]))
              || (mode_q[MB_SEG_EN] && flags_q[1])
              || (mode_q[MB_END_EN] && flags_q[0]);
endmodule

// File: rtl/chain_dma_seq.sv
// Top of the descriptor chain DMA sequencer: register block plus engine.
// Assumes a memory that answers each held request with one mem_ack cycle.
module chain_dma_seq
    import chain_dma_pkg::*;
#(
    parameter int AW    = 32,
    parameter int CNT_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    output logic              irq,
    output logic              mem_req,
    output logic              mem_we,
    output logic [AW-1:0]     mem_addr,
    output logic [31:0]       mem_wdata,
    input  logic [31:0]       mem_rdata,
    input  logic              mem_ack,
    input  logic              mem_err
);
    logic             go, abort, desc_we, eng_busy, eng_halted;
    logic [AW-1:0]    desc_wdata, desc_addr;
    logic [CNT_W-1:0] byte_cnt;
    evt_t             eng_evt;

    chain_dma_regs #(.AW(AW), .CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .go(go), .abort(abort), .desc_we(desc_we), .desc_wdata(desc_wdata),
        .desc_addr(desc_addr), .byte_cnt(byte_cnt), .eng_busy(eng_busy),
        .eng_halted(eng_halted), .evt(eng_evt)
    );

    chain_dma_engine #(.AW(AW), .CNT_W(CNT_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .go(go), .abort(abort),
        .desc_we(desc_we), .desc_wdata(desc_wdata), .desc_addr(desc_addr),
        .byte_cnt(byte_cnt), .busy(eng_busy), .halted(eng_halted), .evt(eng_evt),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err)
    );
endmodule

// File: rtl/chain_dma_checker.sv
// Protocol and state checks for the sequencer, bound into chain_dma_seq.
// Assumes the memory answers only while a request is held.
module chain_dma_checker #(
    parameter int AW    = 32,
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             busy,
    input logic             halted,
    input logic             mem_req,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic [31:0]      mem_wdata,
    input logic             mem_ack,
    input logic             mem_err,
    input logic             evt_prog,
    input logic             evt_xerr,
    input logic [CNT_W-1:0] byte_cnt
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_req); // R12
    AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[1:0] == 2'b00)); // R3
    AST_BUSY_HALT_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && halted)); // R8
    AST_ERR_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ack && mem_err) |=> (halted && !busy && evt_xerr)); // R9
    AST_PROG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_prog |-> (halted && !busy && byte_cnt == '0)); // R7
endmodule

bind chain_dma_seq chain_dma_checker #(.AW(AW), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(eng_busy), .halted(eng_halted),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_err(mem_err),
    .evt_prog(eng_evt.prog_err), .evt_xerr(eng_evt.xfer_err),
    .byte_cnt(byte_cnt)
);

// File: tb/chain_dma_seq_test.sv
// Bench for chain_dma_seq: a vector table of single-descriptor copies, then directed tests.
module chain_dma_seq_test;
    localparam int AW = 32;
    localparam logic [31:0] S_END = 32'h01, S_SEG = 32'h02, S_BUSY = 32'h04,
                            S_HALT = 32'h08, S_PROG = 32'h10, S_XERR = 32'h20;
    localparam logic [31:0] C_START = 32'h1, C_ABORT = 32'h2, C_ERR = 32'h4,
                            C_SEG = 32'h8, C_END = 32'h10;

    typedef struct packed {
        logic [31:0] src;
        logic [31:0] dst;
        logic [31:0] cnt;
        logic        seg;
    } vec_t;
    localparam vec_t VECS [4] = '{
        '{32'h100, 32'h200, 32'd16,     1'b1},
        '{32'h140, 32'h240, 32'd4,      1'b0},
        '{32'h180, 32'h280, 32'h1007,   1'b0},
        '{32'h1C0, 32'h2C0, 32'd40,     1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq, mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [31:0] mem_wdata;
    logic [31:0] mem_rdata = '0;
    logic        mem_ack = 1'b0;
    logic        mem_err = 1'b0;

    logic [31:0] mem [0:255];
    logic        err_en = 1'b0;
    logic [31:0] err_addr = '0;
    int          checks = 0;
    int          fails = 0;
    int          hs_viol = 0;
    logic        pend = 1'b0;
    logic [31:0] pend_addr = '0;

    always #10 clk = ~clk;

    chain_dma_seq uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ack(mem_ack),
        .mem_err(mem_err)
    );

    // Memory model: acknowledges a held request one cycle after seeing it
    always @(posedge clk) begin
        if (mem_req && !mem_ack) begin
            mem_ack <= 1'b1;
            mem_err <= err_en && (mem_addr == err_addr);
            if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
            else mem_rdata <= mem[mem_addr[9:2]];
        end else begin
            mem_ack <= 1'b0;
            mem_err <= 1'b0;
        end
    end

    // Handshake monitor for R12: a pending request must persist unchanged
    always @(negedge clk) begin
        if (rst_n && pend && (!mem_req || mem_addr != pend_addr)) hs_viol++;
        pend      <= mem_req && !mem_ack;
        pend_addr <= mem_addr;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic reg_write(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic reg_read(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic put_desc(input logic [31:0] base, input logic [31:0] cnt,
                            input logic [31:0] src, input logic [31:0] dst,
                            input logic [31:0] link);
        mem[base[9:2]]     = cnt;
        mem[base[9:2] + 1] = src;
        mem[base[9:2] + 2] = dst;
        mem[base[9:2] + 3] = link;
    endtask

    task automatic fill(input logic [31:0] src, input int n, input logic [31:0] pat,
                        input logic [31:0] dst);
        for (int w = 0; w < n; w++) mem[src[9:2] + w] = pat + w;
        for (int w = 0; w <= n; w++) mem[dst[9:2] + w] = 32'hDEAD_0000 + w;
    endtask

    task automatic check_copy(input string tag, input logic [31:0] dst, input int n,
                              input logic [31:0] pat);
        for (int w = 0; w < n; w++) check(tag, mem[dst[9:2] + w], pat + w);
        check(tag, mem[dst[9:2] + n], 32'hDEAD_0000 + n);
    endtask

    task automatic launch(input logic [31:0] base, input logic [31:0] en);
        reg_write(2'd1, 32'h3F);
        reg_write(2'd0, en);
        reg_write(2'd2, base);
        reg_write(2'd0, en | C_START);
    endtask

    task automatic wait_idle(input string tag);
        logic [31:0] s;
        for (int k = 0; k < 4000; k++) begin
            reg_read(2'd1, s);
            if (!s[2]) return;
        end
        check(tag, 32'h1, 32'h0);
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int n;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        reg_read(2'd0, r); check("R1 mode", r, 32'h0);
        reg_read(2'd1, r); check("R1 status", r, 32'h0);
        reg_read(2'd2, r); check("R1 desc", r, 32'h0);
        reg_read(2'd3, r); check("R1 count", r, 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);
        check("R1 req", {31'b0, mem_req}, 32'h0);

        // Vector table: single descriptors, R3 R5 R6
        for (int i = 0; i < 4; i++) begin
            n = int'(((VECS[i].cnt & 32'hFFF) & ~32'h3) >> 2);
            fill(VECS[i].src, n, 32'hA000_0000 | (i << 8), VECS[i].dst);
            put_desc(32'h000, VECS[i].cnt, VECS[i].src, VECS[i].dst,
                     32'h60 | 32'h1 | (VECS[i].seg ? 32'h2 : 32'h0));
            launch(32'h000, 32'h0);
            reg_read(2'd1, r); check("R2 busy after start", r & S_BUSY, S_BUSY);
            wait_idle("R5 completes");
            check_copy("R3 copy", VECS[i].dst, n, 32'hA000_0000 | (i << 8));
            reg_read(2'd1, r);
            check("R5 R6 status", r, S_END | (VECS[i].seg ? S_SEG : 32'h0));
            reg_read(2'd3, r); check("R13 count done", r, 32'h0);
        end

        // Three-descriptor chain with stray low bits in a link, R4
        fill(32'h100, 2, 32'hB100_0000, 32'h200);
        fill(32'h120, 3, 32'hB200_0000, 32'h220);
        fill(32'h140, 1, 32'hB300_0000, 32'h240);
        put_desc(32'h000, 32'd8,  32'h100, 32'h200, 32'h020 | 32'h10);
        put_desc(32'h020, 32'd12, 32'h120, 32'h220, 32'h040 | 32'h2);
        put_desc(32'h040, 32'd4,  32'h140, 32'h240, 32'h060 | 32'h1);
        launch(32'h000, 32'h0);
        wait_idle("R4 chain");
        check_copy("R4 chain d0", 32'h200, 2, 32'hB100_0000);
        check_copy("R4 chain d1", 32'h220, 3, 32'hB200_0000);
        check_copy("R4 chain d2", 32'h240, 1, 32'hB300_0000);
        reg_read(2'd2, r); check("R4 desc addr", r, 32'h040);
        reg_read(2'd1, r); check("R5 chain status", r, S_END | S_SEG);

        // Interrupt gating and write-one-to-clear, R10 R11
        check("R11 no enables", {31'b0, irq}, 32'h0);
        reg_write(2'd0, C_END);
        check("R11 end enabled", {31'b0, irq}, 32'h1);
        reg_write(2'd1, 32'h0);
        reg_read(2'd1, r); check("R10 zero write keeps", r, S_END | S_SEG);
        reg_write(2'd1, S_END);
        reg_read(2'd1, r); check("R10 clear end", r, S_SEG);
        check("R11 end cleared", {31'b0, irq}, 32'h0);
        reg_write(2'd0, C_SEG);
        check("R11 seg enabled", {31'b0, irq}, 32'h1);
        reg_write(2'd1, S_SEG | S_BUSY | S_HALT);
        reg_read(2'd1, r); check("R10 clear seg, busy/halt unwritable", r, 32'h0);
        check("R11 seg cleared", {31'b0, irq}, 32'h0);

        // Descriptor address write ignored while busy; count falls, R13
        fill(32'h100, 64, 32'hC000_0000, 32'h200);
        put_desc(32'h000, 32'd256, 32'h100, 32'h200, 32'h1);
        launch(32'h000, 32'h0);
        reg_write(2'd2, 32'h0A0);
        repeat (40) @(negedge clk);
        reg_read(2'd3, r);
        check("R13 count mid-run", {31'b0, (r != 0 && r < 256 && r[1:0] == 2'b00)}, 32'h1);
        wait_idle("R13 long copy");
        reg_read(2'd2, r); check("R13 desc write ignored", r, 32'h000);
        check_copy("R13 long copy", 32'h200, 64, 32'hC000_0000);

        // Zero-length descriptor, R7
        fill(32'h100, 0, 32'h0, 32'h200);
        put_desc(32'h000, 32'd3, 32'h100, 32'h200, 32'h1);
        launch(32'h000, C_ERR);
        wait_idle("R7 prog error");
        reg_read(2'd1, r); check("R7 status", r, S_PROG | S_HALT);
        reg_read(2'd3, r); check("R7 count zero", r, 32'h0);
        check("R7 no write", mem[32'h200 >> 2], 32'hDEAD_0000);
        check("R11 error irq", {31'b0, irq}, 32'h1);

        // Abort during a long copy, then restart, R8
        fill(32'h100, 64, 32'hD000_0000, 32'h200);
        put_desc(32'h000, 32'd256, 32'h100, 32'h200, 32'h1);
        launch(32'h000, 32'h0);
        repeat (30) @(negedge clk);
        reg_write(2'd0, C_START | C_ABORT);
        repeat (5) @(negedge clk);
        reg_read(2'd1, r); check("R8 halted after abort", r, S_HALT);
        n = 0;
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (mem_req) n++;
        end
        check("R8 no access after abort", n, 0);
        check("R8 last word untouched", mem[(32'h200 >> 2) + 63], 32'hDEAD_0000 + 63);
        launch(32'h000, 32'h0);
        wait_idle("R8 restart");
        reg_read(2'd1, r); check("R8 restart status", r, S_END);
        check_copy("R8 restart copy", 32'h200, 64, 32'hD000_0000);

        // Memory error on third source read, R9
        fill(32'h100, 4, 32'hE000_0000, 32'h200);
        put_desc(32'h000, 32'd16, 32'h100, 32'h200, 32'h1);
        err_en = 1'b1; err_addr = 32'h108;
        launch(32'h000, 32'h0);
        wait_idle("R9 error stop");
        err_en = 1'b0;
        reg_read(2'd1, r); check("R9 status", r, S_XERR | S_HALT);
        check("R9 word1 copied", mem[(32'h200 >> 2) + 1], 32'hE000_0001);
        check("R9 word2 untouched", mem[(32'h200 >> 2) + 2], 32'hDEAD_0002);

        check("R12 handshake", hs_viol, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule